// File: doc/BRIEF.md
# Row-Grouped Dirty Bit Tracker

This block holds the dirty status of cache lines in a structure kept apart from the cache tag array. It is a small, fully associative table. Each entry is tagged with a DRAM row address and carries one dirty bit for every cache block in that row. Any line that the table does not track is clean. The cache controller issues at most one request per cycle. A request is a query, a set, or a clear, addressed by a row address plus a block offset inside the row.

A set on a row the table does not yet track claims a free entry. When every entry is occupied, the entry written longest ago is pushed out instead. Its row address and its complete bit vector appear on the eviction outputs for one cycle, so the controller can write all of those lines back as one burst to the open DRAM row. A clear that leaves an entry with no dirty bits releases that entry. Query results, like eviction reports, arrive one cycle after the request.

Top module: `row_dirty_tracker`

## Requirements
- R1: Synchronous reset (`rst` high at a clock edge) invalidates every entry. After reset every query reports clean, `rsp_valid` and `evict_valid` are low, and the first NUM_ENTRIES distinct rows that are set cause no eviction.
- R2: Opcodes on `req_op` are 0 = query, 1 = set and 2 = clear. A query accepted with `req_valid` high at edge k drives `rsp_valid` high after edge k, together with `rsp_dirty`. `rsp_dirty` is 1 exactly when a valid entry holds the row and the bit at the offset is set. `rsp_valid` is low after any cycle that held no query.
- R3: A set on a tracked row raises only the bit at `req_off`. Other bits of that row keep their values.
- R4: A set on an untracked row while a free entry exists creates an entry holding only that line's bit, and it produces no eviction.
- R5: A set on an untracked row while all entries are valid evicts the least recently written entry. After that edge `evict_valid` is high for exactly one cycle, with `evict_row` set to the victim row and `evict_bits` set to its full vector, where bit i stands for block offset i. The victim's lines then read clean and the new line reads dirty.
- R6: Only set requests, including sets on bits that are already set, refresh an entry's recency. Queries and clears do not change the replacement order.
- R7: A clear on a tracked row lowers the bit at `req_off`. When the vector becomes all zero, the entry is freed, and a later set on a new row reuses it with no eviction.
- R8: A clear on a line that is not tracked leaves the table unchanged. A set on a bit that is already set changes no bit.
- R9: No two valid entries ever hold the same row address.
- R10: Opcode 3, and any cycle with `req_valid` low, changes no state and produces no response or eviction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 0 query, 1 set, 2 clear, 3 no operation |
| req_row | input | ROW_W | DRAM row address of the line |
| req_off | input | clog2(BLOCKS_PER_ROW) | Block offset inside the row |
| rsp_valid | output | 1 | Query result present (one cycle after the query) |
| rsp_dirty | output | 1 | Queried line is dirty |
| evict_valid | output | 1 | One-cycle pulse: an entry was pushed out |
| evict_row | output | ROW_W | Row address of the evicted entry |
| evict_bits | output | BLOCKS_PER_ROW | Dirty vector of the evicted entry, bit i = offset i |

## Verification
The hardest condition to reach from the ports is a replacement order shaped by every kind of request. A test that only fills the table and then overflows it shows nothing about whether queries, clears or repeated sets on an already-dirty bit move recency. The stimulus therefore fills a four-entry table, re-sets an already-dirty bit on the oldest row, queries and clears other rows, and then overflows the table several times. Each victim's row and vector must match the order that only sets define. A clear that empties an entry comes between two overflows, so that reusing the freed slot shows up as a missing eviction.

// File: rtl/dbt_pkg.sv
package dbt_pkg;

  // Request opcodes carried on req_op.
  typedef enum logic [1:0] {
    OP_QUERY = 2'd0,
    OP_SET   = 2'd1,
    OP_CLEAR = 2'd2,
    OP_NONE  = 2'd3
  } dbt_op_e;

endpackage

// File: rtl/dbt_tag_match.sv
// Associative row match across all entries, plus a free-slot search.
module dbt_tag_match #(
  parameter int NUM_ENTRIES = 16,
  parameter int ROW_W       = 28,
  parameter int IDX_W       = 4
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [NUM_ENTRIES-1:0]           ent_valid,
  input  logic [NUM_ENTRIES-1:0][ROW_W-1:0] ent_tag,
  input  logic [ROW_W-1:0]                 look_row,
  output logic                             hit,
  output logic [IDX_W-1:0]                 hit_idx,
  output logic                             free_avail,
  output logic [IDX_W-1:0]                 free_idx
);

  logic [NUM_ENTRIES-1:0] hit_vec;
  logic [NUM_ENTRIES-1:0] free_vec;

  // Lowest set position of a vector; 0 when empty.
  function automatic logic [IDX_W-1:0] lowest_set(input logic [NUM_ENTRIES-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (v[i]) r = IDX_W'(i);
    end
    return r;
  endfunction

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cmp
    assign hit_vec[g]  = ent_valid[g] && (ent_tag[g] == look_row);
    assign free_vec[g] = ~ent_valid[g];
  end

  assign hit        = |hit_vec;
  assign hit_idx    = lowest_set(hit_vec);
  assign free_avail = |free_vec;
  assign free_idx   = lowest_set(free_vec);

  // At most one entry may ever own a given row.
  assert_unique_row_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec));

endmodule

// File: rtl/dbt_lrw_order.sv
// Least-recently-written order kept as a rank permutation (0 = newest).
module dbt_lrw_order #(
  parameter int NUM_ENTRIES = 16,
  parameter int IDX_W       = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_idx,
  output logic [IDX_W-1:0] victim_idx
);

  localparam logic [IDX_W-1:0] OLDEST = IDX_W'(NUM_ENTRIES - 1);

  logic [NUM_ENTRIES-1:0][IDX_W-1:0] rank_q;
  logic [NUM_ENTRIES-1:0]            oldest_vec;
  logic [IDX_W-1:0]                  touch_rank;

  // Entry holding the oldest rank.
  function automatic logic [IDX_W-1:0] pick_oldest(input logic [NUM_ENTRIES-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (v[i]) r = IDX_W'(i);
    end
    return r;
  endfunction

  assign touch_rank = rank_q[touch_idx];

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_rank
    assign oldest_vec[g] = (rank_q[g] == OLDEST);

    always_ff @(posedge clk) begin
      if (rst) begin
        rank_q[g] <= IDX_W'(g);
      end else if (touch_en) begin
        if (touch_idx == IDX_W'(g)) begin
          rank_q[g] <= '0;
        end else if (rank_q[g] < touch_rank) begin
          rank_q[g] <= rank_q[g] + 1'b1;
        end
      end
    end
  end

  assign victim_idx = pick_oldest(oldest_vec);

  // The ranks stay a permutation, so exactly one entry is oldest.
  assert_one_oldest_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot(oldest_vec));

  // A written entry becomes the newest.
  assert_touch_newest_R6: assert property (@(posedge clk) disable iff (rst)
    touch_en |=> (rank_q[$past(touch_idx)] == '0));

endmodule

// File: rtl/row_dirty_tracker.sv
module row_dirty_tracker #(
  parameter int NUM_ENTRIES    = 16,
  parameter int BLOCKS_PER_ROW = 64,
  parameter int ROW_W          = 28
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              req_valid,
  input  logic [1:0]                        req_op,
  input  logic [ROW_W-1:0]                  req_row,
  input  logic [$clog2(BLOCKS_PER_ROW)-1:0] req_off,
  output logic                              rsp_valid,
  output logic                              rsp_dirty,
  output logic                              evict_valid,
  output logic [ROW_W-1:0]                  evict_row,
  output logic [BLOCKS_PER_ROW-1:0]         evict_bits
);
  import dbt_pkg::*;

  localparam int OFF_W = $clog2(BLOCKS_PER_ROW);
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;

  // Table storage.
  logic [NUM_ENTRIES-1:0]                     ent_valid;
  logic [NUM_ENTRIES-1:0][ROW_W-1:0]          ent_tag;
  logic [NUM_ENTRIES-1:0][BLOCKS_PER_ROW-1:0] ent_bits;

  // Output registers.
  logic                      rsp_valid_q, rsp_dirty_q, evict_valid_q;
  logic [ROW_W-1:0]          evict_row_q;
  logic [BLOCKS_PER_ROW-1:0] evict_bits_q;

  // Named internal events.
  dbt_op_e                   op_e;
  logic                      is_query, is_set, is_clear;
  logic                      hit, free_avail;
  logic [IDX_W-1:0]          hit_idx, free_idx, victim_idx, alloc_idx, touch_idx;
  logic [BLOCKS_PER_ROW-1:0] req_mask, hit_bits, cleared_bits;
  logic                      set_hit, alloc_evt, evict_evt, clr_hit, free_evt, touch_en;

  // One-hot mask selecting the block at a given offset.
  function automatic logic [BLOCKS_PER_ROW-1:0] line_mask(input logic [OFF_W-1:0] off);
    logic [BLOCKS_PER_ROW-1:0] m;
    m      = '0;
    m[off] = 1'b1;
    return m;
  endfunction

  assign op_e     = dbt_op_e'(req_op);
  assign is_query = req_valid && (op_e == OP_QUERY);
  assign is_set   = req_valid && (op_e == OP_SET);
  assign is_clear = req_valid && (op_e == OP_CLEAR);

  dbt_tag_match #(
    .NUM_ENTRIES(NUM_ENTRIES),
    .ROW_W      (ROW_W),
    .IDX_W      (IDX_W)
  ) u_match (
    .clk       (clk),
    .rst       (rst),
    .ent_valid (ent_valid),
    .ent_tag   (ent_tag),
    .look_row  (req_row),
    .hit       (hit),
    .hit_idx   (hit_idx),
    .free_avail(free_avail),
    .free_idx  (free_idx)
  );

  dbt_lrw_order #(
    .NUM_ENTRIES(NUM_ENTRIES),
    .IDX_W      (IDX_W)
  ) u_order (
    .clk       (clk),
    .rst       (rst),
    .touch_en  (touch_en),
    .touch_idx (touch_idx),
    .victim_idx(victim_idx)
  );

  assign req_mask     = line_mask(req_off);
  assign hit_bits     = ent_bits[hit_idx];
  assign cleared_bits = hit_bits & ~req_mask;

  assign set_hit   = is_set && hit;
  assign alloc_evt = is_set && !hit;
  assign evict_evt = alloc_evt && !free_avail;
  assign alloc_idx = free_avail ? free_idx : victim_idx;
  assign clr_hit   = is_clear && hit;
  assign free_evt  = clr_hit && (cleared_bits == '0);
  assign touch_en  = is_set;
  assign touch_idx = hit ? hit_idx : alloc_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      ent_valid     <= '0;
      ent_tag       <= '0;
      ent_bits      <= '0;
      rsp_valid_q   <= 1'b0;
      rsp_dirty_q   <= 1'b0;
      evict_valid_q <= 1'b0;
      evict_row_q   <= '0;
      evict_bits_q  <= '0;
    end else begin
      rsp_valid_q   <= is_query;
      rsp_dirty_q   <= is_query && hit && ((hit_bits & req_mask) != '0);
      evict_valid_q <= evict_evt;
      if (evict_evt) begin
        evict_row_q  <= ent_tag[victim_idx];
        evict_bits_q <= ent_bits[victim_idx];
      end
      if (set_hit) begin
        ent_bits[hit_idx] <= hit_bits | req_mask;
      end
      if (alloc_evt) begin
        ent_valid[alloc_idx] <= 1'b1;
        ent_tag[alloc_idx]   <= req_row;
        ent_bits[alloc_idx]  <= req_mask;
      end
      if (clr_hit) begin
        ent_bits[hit_idx] <= cleared_bits;
        if (free_evt) ent_valid[hit_idx] <= 1'b0;
      end
    end
  end

  assign rsp_valid   = rsp_valid_q;
  assign rsp_dirty   = rsp_dirty_q;
  assign evict_valid = evict_valid_q;
  assign evict_row   = evict_row_q;
  assign evict_bits  = evict_bits_q;

  // A valid entry always holds at least one dirty bit.
  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_inv
    assert_entry_nonempty_R7: assert property (@(posedge clk) disable iff (rst)
      ent_valid[g] |-> (ent_bits[g] != '0));
  end

  assert_rsp_after_query_R2: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(req_valid && (req_op == 2'd0)));

  assert_evict_after_set_R5: assert property (@(posedge clk) disable iff (rst)
    evict_valid |-> ($past(req_valid && (req_op == 2'd1)) && (evict_bits != '0)
                     && (evict_row != $past(req_row))));

  assert_set_raises_bit_R3: assert property (@(posedge clk) disable iff (rst)
    set_hit |=> ent_bits[$past(hit_idx)][$past(req_off)]);

  assert_clear_untracked_R8: assert property (@(posedge clk) disable iff (rst)
    (is_clear && !hit) |=> ($stable(ent_valid) && $stable(ent_bits)));

  assert_idle_no_change_R10: assert property (@(posedge clk) disable iff (rst)
    !(is_set || is_clear) |=> ($stable(ent_valid) && $stable(ent_bits) && !evict_valid));

endmodule

// File: tb/row_dirty_tracker_tb.sv
module row_dirty_tracker_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NE = 4;
  localparam int NB = 8;
  localparam int RW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic [1:0]    req_op = 2'd0;
  logic [RW-1:0] req_row = '0;
  logic [2:0]    req_off = '0;
  logic          rsp_valid, rsp_dirty, evict_valid;
  logic [RW-1:0] evict_row;
  logic [NB-1:0] evict_bits;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  row_dirty_tracker #(
    .NUM_ENTRIES   (NE),
    .BLOCKS_PER_ROW(NB),
    .ROW_W         (RW)
  ) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_row(req_row), .req_off(req_off), .rsp_valid(rsp_valid),
    .rsp_dirty(rsp_dirty), .evict_valid(evict_valid),
    .evict_row(evict_row), .evict_bits(evict_bits)
  );

  typedef struct packed {
    logic [1:0]    op;
    logic [RW-1:0] row;
    logic [2:0]    off;
    logic          dirty;  // expected rsp_dirty for queries
    logic          ev;     // expected eviction pulse
    logic [RW-1:0] erow;
    logic [NB-1:0] ebits;
    logic [3:0]    rq;     // requirement number for the message
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 8'd10, 3'd3, 1'b0, 1'b0, 8'd0,  8'h00, 4'd1},  // R1 empty table reads clean
    '{2'd1, 8'd10, 3'd3, 1'b0, 1'b0, 8'd0,  8'h00, 4'd4},  // R4 allocate row 10
    '{2'd0, 8'd10, 3'd3, 1'b1, 1'b0, 8'd0,  8'h00, 4'd2},  // R2 dirty line
    '{2'd0, 8'd10, 3'd4, 1'b0, 1'b0, 8'd0,  8'h00, 4'd3},  // R3 neighbour untouched
    '{2'd1, 8'd10, 3'd5, 1'b0, 1'b0, 8'd0,  8'h00, 4'd3},  // R3 second bit
    '{2'd0, 8'd10, 3'd5, 1'b1, 1'b0, 8'd0,  8'h00, 4'd3},
    '{2'd1, 8'd20, 3'd0, 1'b0, 1'b0, 8'd0,  8'h00, 4'd4},
    '{2'd1, 8'd30, 3'd1, 1'b0, 1'b0, 8'd0,  8'h00, 4'd4},
    '{2'd1, 8'd40, 3'd7, 1'b0, 1'b0, 8'd0,  8'h00, 4'd4},  // table full
    '{2'd1, 8'd10, 3'd3, 1'b0, 1'b0, 8'd0,  8'h00, 4'd8},  // R8 set on set bit, refreshes
    '{2'd0, 8'd20, 3'd0, 1'b1, 1'b0, 8'd0,  8'h00, 4'd6},  // R6 query, no refresh
    '{2'd2, 8'd99, 3'd2, 1'b0, 1'b0, 8'd0,  8'h00, 4'd8},  // R8 clear untracked
    '{2'd1, 8'd50, 3'd2, 1'b0, 1'b1, 8'd20, 8'h01, 4'd5},  // R5 victim row 20
    '{2'd0, 8'd20, 3'd0, 1'b0, 1'b0, 8'd0,  8'h00, 4'd5},
    '{2'd0, 8'd50, 3'd2, 1'b1, 1'b0, 8'd0,  8'h00, 4'd5},
    '{2'd2, 8'd30, 3'd1, 1'b0, 1'b0, 8'd0,  8'h00, 4'd7},  // R7 frees row 30
    '{2'd0, 8'd30, 3'd1, 1'b0, 1'b0, 8'd0,  8'h00, 4'd7},
    '{2'd1, 8'd60, 3'd4, 1'b0, 1'b0, 8'd0,  8'h00, 4'd7},  // R7 reuse, no eviction
    '{2'd3, 8'd40, 3'd7, 1'b0, 1'b0, 8'd0,  8'h00, 4'd10}, // R10 opcode 3
    '{2'd0, 8'd40, 3'd7, 1'b1, 1'b0, 8'd0,  8'h00, 4'd10},
    '{2'd1, 8'd70, 3'd6, 1'b0, 1'b1, 8'd40, 8'h80, 4'd5},  // R5 victim row 40
    '{2'd2, 8'd10, 3'd3, 1'b0, 1'b0, 8'd0,  8'h00, 4'd7},  // R7 partial clear
    '{2'd0, 8'd10, 3'd5, 1'b1, 1'b0, 8'd0,  8'h00, 4'd7},
    '{2'd0, 8'd10, 3'd3, 1'b0, 1'b0, 8'd0,  8'h00, 4'd7},
    '{2'd1, 8'd80, 3'd0, 1'b0, 1'b1, 8'd10, 8'h20, 4'd6},  // R6 clear did not refresh row 10
    '{2'd0, 8'd99, 3'd2, 1'b0, 1'b0, 8'd0,  8'h00, 4'd8}
  };

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // Present one request; return just after the edge that accepts it.
  task automatic do_op(input logic [1:0] op, input logic [RW-1:0] row, input logic [2:0] off);
    @(negedge clk);
    req_valid = 1'b1;
    req_op    = op;
    req_row   = row;
    req_off   = off;
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 rsp_valid in reset", {31'd0, rsp_valid}, 32'd0);
    chk("R1 evict_valid in reset", {31'd0, evict_valid}, 32'd0);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      do_op(VECS[i].op, VECS[i].row, VECS[i].off);
      chk($sformatf("R%0d vec%0d rsp_valid", VECS[i].rq, i), {31'd0, rsp_valid},
          {31'd0, VECS[i].op == 2'd0});
      if (VECS[i].op == 2'd0)
        chk($sformatf("R%0d vec%0d rsp_dirty", VECS[i].rq, i), {31'd0, rsp_dirty},
            {31'd0, VECS[i].dirty});
      chk($sformatf("R%0d vec%0d evict_valid", VECS[i].rq, i), {31'd0, evict_valid},
          {31'd0, VECS[i].ev});
      if (VECS[i].ev) begin
        chk($sformatf("R%0d vec%0d evict_row", VECS[i].rq, i), {24'd0, evict_row},
            {24'd0, VECS[i].erow});
        chk($sformatf("R%0d vec%0d evict_bits", VECS[i].rq, i), {24'd0, evict_bits},
            {24'd0, VECS[i].ebits});
      end
    end

    // R5: the eviction pulse lasts one cycle; R10: idle produces nothing.
    idle();
    chk("R5 evict pulse ends", {31'd0, evict_valid}, 32'd0);
    chk("R10 idle no response", {31'd0, rsp_valid}, 32'd0);

    // R1: reset mid-run wipes the table.
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    chk("R1 rsp_valid after reset", {31'd0, rsp_valid}, 32'd0);
    chk("R1 evict_valid after reset", {31'd0, evict_valid}, 32'd0);
    @(negedge clk);
    rst = 1'b0;
    do_op(2'd0, 8'd50, 3'd2);
    chk("R1 query clean after reset", {31'd0, rsp_dirty}, 32'd0);
    for (int r = 1; r <= NE; r++) begin
      do_op(2'd1, 8'(r), 3'd0);
      chk("R1 fill after reset no evict", {31'd0, evict_valid}, 32'd0);
    end
    do_op(2'd1, 8'd200, 3'd1);
    chk("R5 overflow after reset evict", {31'd0, evict_valid}, 32'd1);
    chk("R5 overflow victim row", {24'd0, evict_row}, 32'd1);
    chk("R5 overflow victim bits", {24'd0, evict_bits}, 32'h01);
    do_op(2'd0, 8'd200, 3'd1);
    chk("R4 new line dirty", {31'd0, rsp_dirty}, 32'd1);
    idle();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule